// File: doc/BRIEF.md
# Pulse Train Generator with Skipped Slot

This block turns one fixed input clock into a square pulse train that carries a gap: it emits N pulses, leaves one pulse slot empty, and then repeats the pattern. The waveform comes from the least significant bit of a binary cycle counter. A comparator watches the count against a programmable terminal value. When the count reaches that value, the high phase of that slot is masked and the count restarts from zero. To get N pulses per frame, program the terminal to 2*N+1.

A clock-enable divider sits in front of the counter. It lets the counter advance only once every D input clocks, so a single fast clock can cover a wide range of pulse rates without making a derived clock. The terminal value and the divide ratio arrive as parallel inputs. They are sampled during reset and again each time the counter wraps, so a frame that is already running always finishes with the settings it started with. The output comes from a flip-flop, so it is free of glitches and lags the count by one clock.

Top module: `pulse_train_skip`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and the divider are cleared, `pulseOut` is low after that edge, and `termIn`/`divIn` are sampled as the active settings.
- R2: After each edge, `pulseOut` equals bit 0 of the count held before that edge, gated as given in R4 and R9. The output is high on odd counts and low on even counts, one clock after the count.
- R3: When the counter advances while it equals the active terminal value, it returns to 0. Otherwise it advances by 1. The count never exceeds the active terminal value.
- R4: While the count equals the active terminal value, the registered output is forced low. With terminal 2*N+1, each frame holds exactly N pulses followed by one empty slot.
- R5: A frame lasts (terminal+1) counter advances.
- R6: A divide ratio of 0 or 1 lets the counter advance on every clock.
- R7: A divide ratio D of 2 or more lets the counter advance once every D clocks. The output therefore changes only on those advances.
- R8: A change to `termIn` or `divIn` outside reset takes effect only at the advance that wraps the counter to 0.
- R9: An active terminal value below 3 keeps `pulseOut` low at all times. The counter still cycles between 0 and the terminal value.
- R10: With the maximum terminal value 255, each frame holds 127 pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| termIn | input | 8 | Terminal count (2*N+1 for N pulses per frame) |
| divIn | input | 8 | Clock-enable divide ratio (0 and 1 mean no division) |
| pulseOut | output | 1 | Registered pulse train |

## Verification
The bench builds the block with its default 8-bit counter and 8-bit divider, so it can reach the largest terminal value of 255 and frames of 127 pulses. Divide ratios of 0, 1 and 3 exercise both the undivided path and the enabled path. Terminal values of 0, 1, 5, 9 and 255 cover the degenerate low range, short frames and the counter's full range. A settings change made in the middle of a frame shows whether the block defers it to the wrap.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef struct packed {
    logic advance;  // counter may step this clock
    logic clear;    // count is at terminal: wrap to zero
    logic mask;     // force output low for this slot
  } ptsStrobes_t;
endpackage

// File: rtl/pts_ctrl.sv
module pts_ctrl
  import pts_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] termIn,
  input  logic [DIV_W-1:0] divIn,
  input  logic [CNT_W-1:0] count,
  output ptsStrobes_t      strb
);
  localparam logic [CNT_W-1:0] MIN_TERM = CNT_W'(3);
  localparam logic [DIV_W-1:0] ONE_DIV  = DIV_W'(1);

  logic [CNT_W-1:0] termQ;
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             atTerm;
  logic             wrap;

  always_comb begin
    tick   = (divQ <= ONE_DIV) || (divCnt == divQ - ONE_DIV);
    atTerm = (count == termQ);
    wrap   = tick && atTerm;
    strb.advance = tick;
    strb.clear   = atTerm;
    strb.mask    = atTerm || (termQ < MIN_TERM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      termQ  <= termIn;
      divQ   <= divIn;
    end else begin
      divCnt <= tick ? '0 : divCnt + ONE_DIV;
      if (wrap) begin
        termQ <= termIn;
        divQ  <= divIn;
      end
    end
  end

  // R3: the count reported by the datapath never passes the terminal
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= termQ);
  // R7: divider phase stays below the ratio
  assert_div_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (divQ > ONE_DIV) |-> (divCnt < divQ));
  // R8: settings hold unless the counter wrapped
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(termQ) && $stable(divQ)));
endmodule

// File: rtl/pts_datapath.sv
module pts_datapath
  import pts_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ptsStrobes_t      strb,
  output logic [CNT_W-1:0] count,
  output logic             pulseOut
);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      pulseOut <= 1'b0;
    end else begin
      if (strb.advance) count <= strb.clear ? '0 : count + ONE_CNT;
      pulseOut <= count[0] & ~strb.mask;
    end
  end

  // R2: a high output always follows an odd count
  assert_odd_source_R2: assert property (@(posedge clk) disable iff (rst)
    pulseOut |-> $past(count[0]));
  // R4: a masked slot yields a low output
  assert_mask_low_R4: assert property (@(posedge clk) disable iff (rst)
    strb.mask |=> !pulseOut);
  // R3: stepping at terminal lands on zero
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && strb.clear) |=> (count == '0));
  // R7: without an enable the count holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> $stable(count));
endmodule

// File: rtl/pulse_train_skip.sv
module pulse_train_skip
  import pts_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] termIn,
  input  logic [DIV_W-1:0] divIn,
  output logic             pulseOut
);
  ptsStrobes_t      strb;
  logic [CNT_W-1:0] count;

  pts_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst(rst), .termIn(termIn), .divIn(divIn),
    .count(count), .strb(strb)
  );

  pts_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .count(count), .pulseOut(pulseOut)
  );
endmodule

// File: tb/pulse_train_skip_tb.sv
module pulse_train_skip_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] termIn = 8'd9;
  logic [7:0] divIn = 8'd1;
  logic       pulseOut;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R2";

  // behavioural reference state
  int mCnt = 0, mDivCnt = 0, mTerm = 0, mDiv = 0;
  bit mOut = 0;

  always #2 clk = ~clk;  // 250 MHz

  pulse_train_skip u_dut (
    .clk(clk), .rst(rst), .termIn(termIn), .divIn(divIn), .pulseOut(pulseOut)
  );

  always @(posedge clk) begin
    bit nOut;
    bit tick;
    if (rst) begin
      mCnt = 0; mDivCnt = 0; mTerm = int'(termIn); mDiv = int'(divIn); mOut = 0;
    end else begin
      nOut = (mCnt % 2 == 1) && (mCnt != mTerm) && (mTerm >= 3);
      tick = (mDiv <= 1) || (mDivCnt == mDiv - 1);
      if (tick) begin
        if (mCnt == mTerm) begin
          mCnt = 0; mTerm = int'(termIn); mDiv = int'(divIn);
        end else mCnt = mCnt + 1;
        mDivCnt = 0;
      end else mDivCnt = mDivCnt + 1;
      mOut = nOut;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: compare against the model at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(curReq, int'(pulseOut), int'(mOut));
  endtask

  task automatic doReset(input logic [7:0] t, input logic [7:0] d);
    @(negedge clk);
    rst = 1'b1; termIn = t; divIn = d;
    repeat (2) @(negedge clk);
    check("R1", int'(pulseOut), 0);
    rst = 1'b0;
  endtask

  // run n clocks, count rising edges of the output
  task automatic countRises(input int n, output int rises);
    bit prev;
    prev = pulseOut;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pulseOut && !prev) rises++;
      prev = pulseOut;
    end
  endtask

  initial begin
    int r;
    // R1 reset state, R4 R5 R6 with divide ratio 1
    doReset(8'd9, 8'd1);
    curReq = "R4";
    countRises(60, r);
    check("R4 R5 R6 terminal 9 div 1", r, 24);
    // R6 ratio 0
    doReset(8'd9, 8'd0);
    curReq = "R6";
    countRises(60, r);
    check("R6 div 0", r, 24);
    // R7 ratio 3 with terminal 5
    doReset(8'd5, 8'd3);
    curReq = "R7";
    countRises(72, r);
    check("R7 div 3", r, 8);
    // R8 mid-frame change, model decides when it lands
    doReset(8'd9, 8'd1);
    curReq = "R8";
    repeat (3) step();
    termIn = 8'd5; divIn = 8'd2;
    repeat (6) step();
    check("R8 unchanged before wrap", int'(pulseOut), int'(mOut));
    repeat (40) step();
    termIn = 8'd9; divIn = 8'd1;
    repeat (20) step();
    // R9 low terminals
    doReset(8'd1, 8'd1);
    curReq = "R9";
    countRises(50, r);
    check("R9 terminal 1", r, 0);
    doReset(8'd0, 8'd1);
    countRises(50, r);
    check("R9 terminal 0", r, 0);
    // R10 maximum terminal
    doReset(8'd255, 8'd0);
    curReq = "R10";
    countRises(512, r);
    check("R10 terminal 255", r, 254);
    // R2 general compare with varied settings
    doReset(8'd7, 8'd4);
    curReq = "R2";
    repeat (100) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule